// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host a small configuration space through just two byte locations. Location 0 is the selector and location 1 is the data window. The host first writes an open key to the selector. It then writes a register number to the selector and moves data through the window. A close key written to the selector shuts the space again. Behind the pair sit identification bytes that the host can only read, a 16-bit base address split into a high and a low byte, and an enable bit. Together the base and the enable switch on the device's data-register window.

The identification bytes are vendor ID, product ID and chip version, each low and high, and they come from parameters. After power-up, and again after every resume from suspend, the host runs the same sequence:

1. Open the space.
2. Program the two base bytes.
3. Read the base bytes back to confirm them.
4. Write 1 to the enable register.
5. Close the space.

A write takes effect at the next rising clock edge. A read is combinational on the current state.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the space is closed, the selected register number is 0x00, `base_addr` is 0x0000 and `win_en` is 0.
- R2: Writing 0x55 to location 0 opens the space and writing 0xAA closes it. Neither key value is ever stored as a register number.
- R3: While the space is closed, reads of either location return 0xFF. Writes to location 1, and writes to location 0 other than 0x55, have no effect.
- R4: While the space is open, writing any value other than the two keys to location 0 selects that register number. A read of location 0 then returns it.
- R5: Reading location 1 returns the identification bytes for these register numbers:
  - 0xF1 returns the vendor ID low byte and 0xF2 the high byte.
  - 0xF3 returns the product ID low byte and 0xF4 the high byte.
  - 0x20 returns the chip version low byte and 0x21 the high byte.
- R6: Register 0x60 holds the high byte and 0x61 the low byte of the base. A write through location 1 updates `base_addr` on the next cycle, and a read returns the value last written.
- R7: A write to register 0x30 sets the enable bit to bit 0 of the written value, so 0x01 enables. A read returns 0x00 or 0x01, and `win_en` follows the bit.
- R8: Writes to identification bytes or to unmapped register numbers change nothing. Reads of unmapped numbers return 0x00.
- R9: Closing the space keeps the base, the enable bit and the selected register number. Reopening reads back the same values.
- R10: Running the configuration sequence again while the window is enabled moves `base_addr` byte by byte, one cycle after each write, without clearing `win_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for the two-location pair |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = selector location, 1 = data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed location |
| base_addr | output | 16 | Programmed data-register base |
| win_en | output | 1 | Data-register window enabled |

## Verification
A write to location 0 does two jobs in the same cycle: it is checked as a key and it is a candidate register number. The bench provokes this by writing 0x55 while the space is already open. It judges the result by reading location 0 back and expecting the earlier register number.

A base write can also land while the window is already enabled. The bench reprograms both bytes with `win_en` high. It expects `base_addr` to take each new byte exactly one cycle after that byte's write, with the enable bit unchanged throughout.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] KEY_OPEN   = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_CLOSE  = 8'hAA;
    localparam logic [BYTE_W-1:0] IX_VEN_LO  = 8'hF1;
    localparam logic [BYTE_W-1:0] IX_VEN_HI  = 8'hF2;
    localparam logic [BYTE_W-1:0] IX_PRD_LO  = 8'hF3;
    localparam logic [BYTE_W-1:0] IX_PRD_HI  = 8'hF4;
    localparam logic [BYTE_W-1:0] IX_VER_LO  = 8'h20;
    localparam logic [BYTE_W-1:0] IX_VER_HI  = 8'h21;
    localparam logic [BYTE_W-1:0] IX_BASE_HI = 8'h60;
    localparam logic [BYTE_W-1:0] IX_BASE_LO = 8'h61;
    localparam logic [BYTE_W-1:0] IX_ACT     = 8'h30;
    localparam logic [BYTE_W-1:0] RD_CLOSED  = 8'hFF;

    typedef struct packed {
        logic              open;
        logic [BYTE_W-1:0] idx;
    } gate_st_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              act;
    } store_st_t;
endpackage

// File: rtl/cfg_gate.sv
module cfg_gate
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              open_o,
    output logic [BYTE_W-1:0] idx_o
);
    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_wr) begin
            if (wdata == KEY_OPEN) begin
                st_d.open = 1'b1;
            end else if (wdata == KEY_CLOSE) begin
                st_d.open = 1'b0;
            end else if (st_q.open) begin
                st_d.idx = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = st_q.open;
    assign idx_o  = st_q.idx;
endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import cfgport_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dat_wr,
    input  logic [BYTE_W-1:0]   idx,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] base_o,
    output logic                act_o
);
    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dat_wr) begin
            unique case (idx)
                IX_BASE_HI: st_d.hi  = wdata;
                IX_BASE_LO: st_d.lo  = wdata;
                IX_ACT:     st_d.act = wdata[0];
                default:    st_d     = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = {st_q.hi, st_q.lo};
    assign act_o  = st_q.act;
endmodule

// File: rtl/cfg_readout.sv
module cfg_readout
    import cfgport_pkg::*;
#(
    parameter logic [2*BYTE_W-1:0] VENDOR_ID    = 16'h15D1,
    parameter logic [2*BYTE_W-1:0] PRODUCT_ID   = 16'd11,
    parameter logic [2*BYTE_W-1:0] CHIP_VERSION = 16'h0102
) (
    input  logic                open,
    input  logic                addr,
    input  logic [BYTE_W-1:0]   idx,
    input  logic [2*BYTE_W-1:0] base,
    input  logic                act,
    output logic [BYTE_W-1:0]   rdata
);
    localparam int NUM_ID = 3;

    logic [2*BYTE_W-1:0] id_word [NUM_ID];
    logic [BYTE_W-1:0]   id_lo_ix [NUM_ID];
    logic [BYTE_W-1:0]   id_hi_ix [NUM_ID];
    logic [NUM_ID-1:0]   hit_lo, hit_hi;
    logic [BYTE_W-1:0]   id_byte;

    assign id_word[0]  = VENDOR_ID;
    assign id_word[1]  = PRODUCT_ID;
    assign id_word[2]  = CHIP_VERSION;
    assign id_lo_ix[0] = IX_VEN_LO;
    assign id_hi_ix[0] = IX_VEN_HI;
    assign id_lo_ix[1] = IX_PRD_LO;
    assign id_hi_ix[1] = IX_PRD_HI;
    assign id_lo_ix[2] = IX_VER_LO;
    assign id_hi_ix[2] = IX_VER_HI;

    for (genvar g = 0; g < NUM_ID; g++) begin : g_id
        assign hit_lo[g] = (idx == id_lo_ix[g]);
        assign hit_hi[g] = (idx == id_hi_ix[g]);
    end

    always_comb begin
        id_byte = '0;
        for (int k = 0; k < NUM_ID; k++) begin
            if (hit_lo[k]) id_byte = id_byte | id_word[k][BYTE_W-1:0];
            if (hit_hi[k]) id_byte = id_byte | id_word[k][2*BYTE_W-1:BYTE_W];
        end
    end

    always_comb begin
        if (!open) begin
            rdata = RD_CLOSED;
        end else if (!addr) begin
            rdata = idx;
        end else begin
            unique case (idx)
                IX_BASE_HI: rdata = base[2*BYTE_W-1:BYTE_W];
                IX_BASE_LO: rdata = base[BYTE_W-1:0];
                IX_ACT:     rdata = {{(BYTE_W-1){1'b0}}, act};
                default:    rdata = id_byte;
            endcase
        end
    end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfgport_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'h15D1,
    parameter logic [15:0] PRODUCT_ID   = 16'd11,
    parameter logic [15:0] CHIP_VERSION = 16'h0102
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [15:0] base_addr,
    output logic        win_en
);
    logic              open_q;
    logic [BYTE_W-1:0] idx_q;
    logic              sel_wr;
    logic              dat_wr;

    assign sel_wr = bus_sel && bus_we && !bus_addr;
    assign dat_wr = bus_sel && bus_we &&  bus_addr && open_q;

    cfg_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_wr (sel_wr),
        .wdata  (bus_wdata),
        .open_o (open_q),
        .idx_o  (idx_q)
    );

    cfg_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .dat_wr (dat_wr),
        .idx    (idx_q),
        .wdata  (bus_wdata),
        .base_o (base_addr),
        .act_o  (win_en)
    );

    cfg_readout #(
        .VENDOR_ID    (VENDOR_ID),
        .PRODUCT_ID   (PRODUCT_ID),
        .CHIP_VERSION (CHIP_VERSION)
    ) u_read (
        .open  (open_q),
        .addr  (bus_addr),
        .idx   (idx_q),
        .base  (base_addr),
        .act   (win_en),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
    parameter logic [15:0] VENDOR_ID = 16'h15D1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic        bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [15:0] base_addr,
    input logic        win_en,
    input logic        open_q,
    input logic [7:0]  idx_q
);
    // R3: closed space reads back all ones
    assert_closed_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && !open_q) |-> (bus_rdata == 8'hFF));

    // R3: closed data write leaves the configuration alone
    assert_closed_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr && !open_q) |=> ($stable(base_addr) && $stable(win_en)));

    assert_open_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !bus_addr && bus_wdata == 8'h55) |=> (open_q && $stable(idx_q)));

    assert_close_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !bus_addr && bus_wdata == 8'hAA) |=> (!open_q && $stable(idx_q)));

    // R9: without a write the configuration holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=> ($stable(base_addr) && $stable(win_en)));

    assert_vendor_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && bus_addr && idx_q == 8'hF1) |-> (bus_rdata == VENDOR_ID[7:0]));

    // R8: writing a read-only byte changes no output
    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr && idx_q == 8'hF2) |=> ($stable(base_addr) && $stable(win_en)));
endmodule

bind cfg_index_port cfg_index_port_chk #(.VENDOR_ID(VENDOR_ID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .base_addr (base_addr),
    .win_en    (win_en),
    .open_q    (open_q),
    .idx_q     (idx_q)
);

// File: tb/test_cfg_index_port.sv
`timescale 1ns/1ps
module test_cfg_index_port;
    localparam logic [15:0] VEN = 16'h15D1;
    localparam logic [15:0] PRD = 16'd11;
    localparam logic [15:0] VER = 16'h0102;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_addr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] base_addr;
    logic        win_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_hi = '0, m_lo = '0;
    logic       m_act = 1'b0;

    always #2.5 clk = ~clk;

    cfg_index_port #(.VENDOR_ID(VEN), .PRODUCT_ID(PRD), .CHIP_VERSION(VER)) i_cfg_index_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .base_addr(base_addr), .win_en(win_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] ix);
        case (ix)
            8'hF1: return VEN[7:0];
            8'hF2: return VEN[15:8];
            8'hF3: return PRD[7:0];
            8'hF4: return PRD[15:8];
            8'h20: return VER[7:0];
            8'h21: return VER[15:8];
            8'h60: return m_hi;
            8'h61: return m_lo;
            8'h30: return {7'b0, m_act};
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit is_key(input int v);
        return (v == 8'h55) || (v == 8'hAA);
    endfunction

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 base", base_addr, 16'h0000);
        chk("R1 win", {15'b0, win_en}, 16'h0000);
        // R3 closed behaviour
        rd(1'b1, r); chk("R3 closed data read", {8'h0, r}, 16'h00FF);
        rd(1'b0, r); chk("R3 closed index read", {8'h0, r}, 16'h00FF);
        wr(1'b0, 8'h60); wr(1'b1, 8'h12);
        chk("R3 closed write base", base_addr, 16'h0000);
        // R2 open; R1 index reset to zero
        wr(1'b0, 8'h55);
        rd(1'b0, r); chk("R1 R2 index after open", {8'h0, r}, 16'h0000);
        // R4 R5 R8 read sweep
        for (int i = 0; i < 256; i++) begin
            if (!is_key(i)) begin
                wr(1'b0, 8'(i));
                rd(1'b0, r); chk("R4 index readback", {8'h0, r}, 16'(i));
                rd(1'b1, r); chk("R5 R8 data read", {8'h0, r}, {8'h0, exp_rd(8'(i))});
            end
        end
        // R6 R7 R8 write sweep
        for (int i = 0; i < 256; i++) begin
            if (!is_key(i)) begin
                logic [7:0] v;
                v = 8'(i) ^ 8'h3C;
                wr(1'b0, 8'(i)); wr(1'b1, v);
                if (i == 8'h60) m_hi = v;
                if (i == 8'h61) m_lo = v;
                if (i == 8'h30) m_act = v[0];
                chk("R6 R8 base after write", base_addr, {m_hi, m_lo});
                chk("R7 R8 win after write", {15'b0, win_en}, {15'b0, m_act});
                rd(1'b1, r); chk("R6 R8 readback", {8'h0, r}, {8'h0, exp_rd(8'(i))});
            end
        end
        // R7 enable
        wr(1'b0, 8'h30); wr(1'b1, 8'h01); m_act = 1'b1;
        chk("R7 win set", {15'b0, win_en}, 16'h0001);
        rd(1'b1, r); chk("R7 act read", {8'h0, r}, 16'h0001);
        // R2 key while open is not an index
        wr(1'b0, 8'h61); wr(1'b0, 8'h55);
        rd(1'b0, r); chk("R2 key not stored", {8'h0, r}, 16'h0061);
        // R9 close keeps state
        wr(1'b0, 8'hAA);
        rd(1'b1, r); chk("R3 closed read", {8'h0, r}, 16'h00FF);
        wr(1'b1, 8'h99); wr(1'b0, 8'h60);
        chk("R9 base kept", base_addr, {m_hi, m_lo});
        chk("R9 win kept", {15'b0, win_en}, 16'h0001);
        wr(1'b0, 8'h55);
        rd(1'b0, r); chk("R9 index kept", {8'h0, r}, 16'h0061);
        rd(1'b1, r); chk("R9 lo kept", {8'h0, r}, {8'h0, m_lo});
        // R10 reprogram while enabled
        wr(1'b0, 8'h60); wr(1'b1, 8'h12); m_hi = 8'h12;
        chk("R10 hi moves", base_addr, {8'h12, m_lo});
        chk("R10 win held", {15'b0, win_en}, 16'h0001);
        wr(1'b0, 8'h61); wr(1'b1, 8'h34); m_lo = 8'h34;
        chk("R10 lo moves", base_addr, 16'h1234);
        wr(1'b0, 8'h30); wr(1'b1, 8'h01); wr(1'b0, 8'hAA);
        chk("R10 win after resume", {15'b0, win_en}, 16'h0001);
        chk("R10 base after resume", base_addr, 16'h1234);
        // R7 clear
        wr(1'b0, 8'h55); wr(1'b0, 8'h30); wr(1'b1, 8'h00);
        chk("R7 win cleared", {15'b0, win_en}, 16'h0000);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule